// File: doc/BRIEF.md
# Multichannel SPI Channel Controller

This block is an SPI master with four independent channels, all sharing a single serial shift engine. Software, or a DMA engine, reaches it through a 32-bit memory-mapped register port. Each channel keeps its own register set: a configuration word, handshake flags, an enable bit, a transmit word and a receive word. Each channel has its own chip-select pin, its own pair of DMA request lines, and two level events that go to an external interrupt block.

A channel starts a transfer when three things hold: it is enabled, its transmit word has been loaded, and its receive word has been collected. Three configuration fields relax or tighten these conditions:
- a two-bit direction field selects full duplex, receive-only or transmit-only;
- a turbo bit lets a new transfer overwrite an uncollected receive word;
- a force bit keeps chip select asserted even when the module runs in single-channel mode.

Only one channel can own the shifter at a time. Channels that are waiting are served from the lowest index upward.

Top module: `mcspi_ctrl`

## Requirements
- R1: After reset, the registers read as follows.
  - Each channel: configuration 0x060000, status 0x2 (only the transmit-empty flag set), control 0.
  - Module control register at 0x28: 0x4.
  - Offset 0x00: 0x91. Offset 0x14: 1.
  - All DMA requests, events and chip selects are inactive.
- R2: Channel n has its registers at 0x2C + 0x14*n.
  - Offsets within the channel: configuration +0x0, status +0x4, control +0x8, transmit +0xC, receive +0x10.
  - A configuration write keeps bits 22:0. A control write keeps bit 0, the enable.
  - Writes to the status and receive offsets change nothing.
- R3: Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-transfer. Writing the transmit word clears transmit-empty. An enabled channel starts a transfer unless one of these holds:
  - receive-full is set, the direction (config bits 13:12) is not transmit-only (2), and turbo is clear;
  - transmit-empty is set and the direction is not receive-only (1).
- R4: When a transfer starts, end-of-transfer is cleared. When it completes:
  - the transmit word reads 0;
  - end-of-transfer and transmit-empty are set;
  - receive-full is set, unless the direction is transmit-only.
- R5: Reading the receive offset returns the last received word and clears receive-full. The channel can then start its next transfer.
- R6: With turbo (config bit 19) set, a set receive-full flag no longer holds off a transfer.
- R7: The transmit DMA request is high when the channel is enabled, config bit 14 is set, transmit-empty is set and the direction is not receive-only. The receive DMA request is high when the channel is enabled, config bit 15 is set, receive-full is set and the direction is not transmit-only.
- R8: The two events are levels.
  - Transmit-empty event: the channel is enabled, transmit-empty is set and the direction is not receive-only.
  - Receive-full event: the channel is enabled, receive-full is set, the direction is not transmit-only and turbo is clear.
- R9: The shifter uses SPI mode 0. SCLK idles low. Data goes out MSB first, MISO is sampled on the rising edge, and each SCLK half period lasts CLK_DIV clock cycles.
  - A transfer has (config bits 11:7) + 1 bits.
  - A field value below 3 gives 4 bits.
- R10: A channel's chip select goes low for its transfer when single-channel mode (module control bit 0) is clear, or when the channel's force bit (config bit 20) is set. Otherwise the transfer completes with no SCLK pulses, and the receive word keeps its previous value.
- R11: At most one chip select is low at any time. When several channels are waiting, the lowest-numbered channel is served first.
- R12: The register port never back-pressures: reg_ready is always high. A read returns its data with rsp_valid one cycle after it is accepted. Offsets that map to nothing read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Register request ready (always high) |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | AW | Byte offset of the register |
| reg_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | DW | Read data |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCH | Per-channel chip select, active low |
| tx_dreq | output | NCH | Per-channel transmit DMA request |
| rx_dreq | output | NCH | Per-channel receive DMA request |
| tx_empty_evt | output | NCH | Per-channel transmit-empty event level |
| rx_full_evt | output | NCH | Per-channel receive-full event level |

## Verification
The assertions assume that register accesses are word aligned and that a channel's configuration is not rewritten while its own transfer is in flight. The stimulus respects both. It touches only exact register offsets, and before it changes a channel's configuration it waits for end-of-transfer on that channel, or disables the channel first. The serial slave model in the bench changes MISO only on falling SCLK edges, which satisfies the sampling-edge assumption of the shifter.

// File: rtl/mcspi_pkg.sv
package mcspi_pkg;

  // Channel register window
  localparam int CH_BASE   = 'h2C;
  localparam int CH_STRIDE = 'h14;

  // Offsets inside a channel window
  localparam logic [4:0] OFF_CFG  = 5'h00;
  localparam logic [4:0] OFF_STAT = 5'h04;
  localparam logic [4:0] OFF_CTRL = 5'h08;
  localparam logic [4:0] OFF_TX   = 5'h0C;
  localparam logic [4:0] OFF_RX   = 5'h10;

  // Module-level registers
  localparam int ADR_ID     = 'h00;
  localparam int ADR_READY  = 'h14;
  localparam int ADR_MODCTL = 'h28;

  localparam logic [31:0] ID_VALUE     = 32'h91;
  localparam logic [22:0] CFG_RESET    = 23'h060000;
  localparam logic [3:0]  MODCTL_RESET = 4'h4;

  // Configuration field positions
  localparam int CFG_WL_LO   = 7;
  localparam int CFG_WL_HI   = 11;
  localparam int CFG_DIR_LO  = 12;
  localparam int CFG_DIR_HI  = 13;
  localparam int CFG_TXDMA   = 14;
  localparam int CFG_RXDMA   = 15;
  localparam int CFG_TURBO   = 19;
  localparam int CFG_FORCE   = 20;

  typedef enum logic [1:0] {
    DIR_DUPLEX = 2'd0,
    DIR_RXONLY = 2'd1,
    DIR_TXONLY = 2'd2,
    DIR_BAD    = 2'd3
  } dir_e;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_RUN  = 2'd1,
    SH_FIN  = 2'd2
  } shift_state_e;

endpackage

// File: rtl/mcspi_chan.sv
module mcspi_chan
  import mcspi_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [4:0]    acc_off,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  output logic          want_xfer,
  output logic [LW-1:0] xfer_bits,
  output logic [DW-1:0] xfer_word,
  output logic          force_cs,
  input  logic          start_i,
  input  logic          done_i,
  input  logic          upd_rx,
  input  logic [DW-1:0] rx_in,
  output logic          tx_dreq,
  output logic          rx_dreq,
  output logic          tx_evt,
  output logic          rx_evt
);

  logic [22:0]   cfg_q;
  logic          en_q, rxs_q, txs_q, eot_q;
  logic [DW-1:0] tx_q, rx_q;

  dir_e       dir;
  logic [4:0] wl;
  logic [4:0] wl_eff;
  logic       turbo, rx_gate, tx_gate, hold_rx, hold_tx;
  logic       wr_cfg, wr_ctl, wr_tx, rd_rx;

  assign dir     = dir_e'(cfg_q[CFG_DIR_HI:CFG_DIR_LO]);
  assign wl      = cfg_q[CFG_WL_HI:CFG_WL_LO];
  assign turbo   = cfg_q[CFG_TURBO];
  assign rx_gate = (dir != DIR_TXONLY);
  assign tx_gate = (dir != DIR_RXONLY);
  assign hold_rx = rxs_q && rx_gate && !turbo;
  assign hold_tx = txs_q && tx_gate;

  assign wr_cfg = acc_wr && (acc_off == OFF_CFG);
  assign wr_ctl = acc_wr && (acc_off == OFF_CTRL);
  assign wr_tx  = acc_wr && (acc_off == OFF_TX);
  assign rd_rx  = acc_rd && (acc_off == OFF_RX);

  assign want_xfer = en_q && !hold_rx && !hold_tx;
  assign wl_eff    = (wl < 5'd3) ? 5'd3 : wl;
  assign xfer_bits = LW'(wl_eff) + LW'(1);
  assign xfer_word = tx_q;
  assign force_cs  = cfg_q[CFG_FORCE];

  assign tx_dreq = en_q && cfg_q[CFG_TXDMA] && txs_q && tx_gate;
  assign rx_dreq = en_q && cfg_q[CFG_RXDMA] && rxs_q && rx_gate;
  assign tx_evt  = en_q && txs_q && tx_gate;
  assign rx_evt  = en_q && rxs_q && rx_gate && !turbo;

  // Order matters: a read clear loses to a simultaneous completion,
  // and a completion loses to a simultaneous transmit write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      en_q  <= 1'b0;
      rxs_q <= 1'b0;
      txs_q <= 1'b1;
      eot_q <= 1'b0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      if (rd_rx)   rxs_q <= 1'b0;
      if (start_i) eot_q <= 1'b0;
      if (done_i) begin
        tx_q  <= '0;
        eot_q <= 1'b1;
        txs_q <= 1'b1;
        if (rx_gate) rxs_q <= 1'b1;
        if (upd_rx)  rx_q  <= rx_in;
      end
      if (wr_cfg) cfg_q <= acc_wdata[22:0];
      if (wr_ctl) en_q  <= acc_wdata[0];
      if (wr_tx) begin
        tx_q  <= acc_wdata;
        txs_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (acc_off)
      OFF_CFG:  rd_data = DW'(cfg_q);
      OFF_STAT: rd_data = DW'({eot_q, txs_q, rxs_q});
      OFF_CTRL: rd_data = DW'(en_q);
      OFF_TX:   rd_data = tx_q;
      OFF_RX:   rd_data = rx_q;
      default:  rd_data = '0;
    endcase
  end

  // R3: a transmit write always leaves transmit-empty clear
  a_r3_tx_write_clears_txs: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !txs_q);

  // R5: a receive read clears receive-full unless new data lands
  a_r5_rx_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !done_i) |=> !rxs_q);

  // R4: completion raises end-of-transfer
  a_r4_done_sets_eot: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> eot_q);

  // R4: transmit-only completion leaves receive-full untouched
  a_r4_txonly_keeps_rxs: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && dir == DIR_TXONLY && !rxs_q) |=> !rxs_q);

endmodule

// File: rtl/mcspi_shift.sv
module mcspi_shift
  import mcspi_pkg::*;
#(
  parameter int DW      = 32,
  parameter int LW      = 6,
  parameter int CLK_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] word,
  input  logic [LW-1:0] nbits,
  input  logic          sel,
  input  logic          miso,
  output logic          idle,
  output logic          done,
  output logic          got_data,
  output logic [DW-1:0] rx_word,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_on
);

  localparam int IW  = $clog2(DW);
  localparam int DCW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  shift_state_e   state;
  logic [DCW-1:0] cnt;
  logic [IW-1:0]  idx;
  logic [DW-1:0]  txw;
  logic           sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SH_IDLE;
      cnt     <= '0;
      idx     <= '0;
      txw     <= '0;
      rx_word <= '0;
      sel_q   <= 1'b0;
      sclk    <= 1'b0;
    end else begin
      case (state)
        SH_IDLE: begin
          if (start) begin
            txw     <= word;
            sel_q   <= sel;
            rx_word <= '0;
            cnt     <= '0;
            idx     <= IW'(nbits - LW'(1));
            state   <= sel ? SH_RUN : SH_FIN;
          end
        end
        SH_RUN: begin
          if (cnt == DCW'(CLK_DIV - 1)) begin
            cnt <= '0;
            if (!sclk) begin
              sclk    <= 1'b1;
              rx_word <= {rx_word[DW-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (idx == '0) state <= SH_FIN;
              else           idx   <= idx - IW'(1);
            end
          end else begin
            cnt <= cnt + DCW'(1);
          end
        end
        SH_FIN:  state <= SH_IDLE;
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign idle     = (state == SH_IDLE);
  assign done     = (state == SH_FIN);
  assign got_data = sel_q;
  assign cs_on    = (state == SH_RUN);
  assign mosi     = (state == SH_RUN) ? txw[idx] : 1'b0;

  // R9: the serial clock is low whenever no bits are moving
  a_r9_sclk_low_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SH_RUN) |-> !sclk);

  // R9: completion is a single-cycle pulse
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/mcspi_arb.sv
module mcspi_arb #(
  parameter int N   = 4,
  parameter int CHW = 2
) (
  input  logic [N-1:0]   req,
  output logic [N-1:0]   gnt,
  output logic [CHW-1:0] gidx,
  output logic           any
);

  assign gnt = req & (~req + N'(1));
  assign any = |req;

  always_comb begin
    gidx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gnt[i]) gidx = CHW'(i);
    end
  end

endmodule

// File: rtl/mcspi_ctrl.sv
module mcspi_ctrl
  import mcspi_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int CLK_DIV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_valid,
  output logic           reg_ready,
  input  logic           reg_write,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCH-1:0] cs_n,
  output logic [NCH-1:0] tx_dreq,
  output logic [NCH-1:0] rx_dreq,
  output logic [NCH-1:0] tx_empty_evt,
  output logic [NCH-1:0] rx_full_evt
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int LW  = 6;

  logic          acc, acc_wr, acc_rd;
  logic [3:0]    modctl_q;
  logic [DW-1:0] rmux;

  logic [NCH-1:0] ch_hit, ch_want, ch_force, gnt, req;
  logic [DW-1:0]  ch_rdata [NCH];
  logic [DW-1:0]  ch_word  [NCH];
  logic [LW-1:0]  ch_bits  [NCH];

  logic           eng_idle, eng_done, eng_got, eng_cs, any_req;
  logic [DW-1:0]  eng_rx;
  logic [CHW-1:0] gidx, act_q;

  assign reg_ready = 1'b1;
  assign acc       = reg_valid && reg_ready;
  assign acc_wr    = acc && reg_write;
  assign acc_rd    = acc && !reg_write;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      localparam int BASE = CH_BASE + CH_STRIDE * gi;
      logic [4:0] loff;

      assign ch_hit[gi] = (reg_addr >= AW'(BASE)) && (reg_addr < AW'(BASE + CH_STRIDE));
      assign loff       = 5'(reg_addr - AW'(BASE));

      mcspi_chan #(.DW(DW), .LW(LW)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_wr    (acc_wr && ch_hit[gi]),
        .acc_rd    (acc_rd && ch_hit[gi]),
        .acc_off   (loff),
        .acc_wdata (reg_wdata),
        .rd_data   (ch_rdata[gi]),
        .want_xfer (ch_want[gi]),
        .xfer_bits (ch_bits[gi]),
        .xfer_word (ch_word[gi]),
        .force_cs  (ch_force[gi]),
        .start_i   (gnt[gi]),
        .done_i    (eng_done && (act_q == CHW'(gi))),
        .upd_rx    (eng_got),
        .rx_in     (eng_rx),
        .tx_dreq   (tx_dreq[gi]),
        .rx_dreq   (rx_dreq[gi]),
        .tx_evt    (tx_empty_evt[gi]),
        .rx_evt    (rx_full_evt[gi])
      );

      assign cs_n[gi] = !(eng_cs && (act_q == CHW'(gi)));
    end
  endgenerate

  assign req = ch_want & {NCH{eng_idle}};

  mcspi_arb #(.N(NCH), .CHW(CHW)) u_arb (
    .req  (req),
    .gnt  (gnt),
    .gidx (gidx),
    .any  (any_req)
  );

  mcspi_shift #(.DW(DW), .LW(LW), .CLK_DIV(CLK_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (any_req),
    .word     (ch_word[gidx]),
    .nbits    (ch_bits[gidx]),
    .sel      (!modctl_q[0] || ch_force[gidx]),
    .miso     (miso),
    .idle     (eng_idle),
    .done     (eng_done),
    .got_data (eng_got),
    .rx_word  (eng_rx),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_on    (eng_cs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= '0;
      modctl_q  <= MODCTL_RESET;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (any_req) act_q <= gidx;
      if (acc_wr && reg_addr == AW'(ADR_MODCTL)) modctl_q <= reg_wdata[3:0];
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_rdata <= rmux;
    end
  end

  always_comb begin
    rmux = '0;
    if (reg_addr == AW'(ADR_ID))     rmux = ID_VALUE;
    if (reg_addr == AW'(ADR_READY))  rmux = DW'(1);
    if (reg_addr == AW'(ADR_MODCTL)) rmux = DW'(modctl_q);
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) rmux = ch_rdata[i];
    end
  end

  // R11: never more than one chip select low
  a_r11_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R10: a chip select is only low while the shifter is busy
  a_r10_cs_needs_engine: assert property (@(posedge clk) disable iff (!rst_n)
    (~cs_n != '0) |-> !eng_idle);

  // R12: every accepted read is answered on the next cycle
  a_r12_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);

endmodule

// File: tb/mcspi_ctrl_bench.sv
module mcspi_ctrl_bench;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [NCH-1:0] cs_n, tx_dreq, rx_dreq, tx_empty_evt, rx_full_evt;

  always #2.5 clk = ~clk;

  mcspi_ctrl u_mcspi_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
    .tx_empty_evt(tx_empty_evt), .rx_full_evt(rx_full_evt)
  );

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  // serial slave model
  logic [31:0] slv_tx = '0;
  logic [31:0] slv_rx = '0;
  int slv_len = 8;
  int bitk = 0;
  int sclk_rises = 0;
  int cs_falls = 0;
  int cs_log [16];
  wire cs_all_n = &cs_n;

  always @(negedge cs_all_n) begin
    for (int i = 0; i < NCH; i++) if (!cs_n[i] && cs_falls < 16) cs_log[cs_falls] = i;
    cs_falls++;
    bitk = 0;
    slv_rx = '0;
    miso = slv_tx[slv_len-1];
  end
  always @(posedge sclk) begin
    slv_rx = {slv_rx[30:0], mosi};
    sclk_rises++;
  end
  always @(negedge sclk) begin
    bitk++;
    if (bitk < slv_len) miso = slv_tx[slv_len-1-bitk];
  end

  function automatic logic [31:0] cfgw(int dir, int wl, bit dw, bit dr, bit turbo, bit frc);
    return (32'(dir) << 12) | (32'(wl) << 7) | (32'(dw) << 14) | (32'(dr) << 15)
         | (32'(turbo) << 19) | (32'(frc) << 20);
  endfunction
  function automatic logic [31:0] lenmask(int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction
  function automatic logic [7:0] creg(int ch, int off);
    return 8'('h2C + 'h14 * ch + off);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic wait_done(int ch);
    logic [31:0] s;
    int tries;
    repeat (4) @(negedge clk);
    tries = 0;
    s = '0;
    while (!s[2] && tries < 3000) begin
      reg_rd(creg(ch, 4), s);
      tries++;
    end
    if (!s[2]) chk("R4 completion timeout", s, s | 32'h4);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r0;
    int base_rises, base_falls, len;
    logic [31:0] word;
    d = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(8'h00, d); chk("R1 id", d, 32'h91);
    reg_rd(8'h14, d); chk("R1 ready", d, 32'h1);
    reg_rd(8'h28, d); chk("R1 modctl", d, 32'h4);
    for (int c = 0; c < NCH; c++) begin
      reg_rd(creg(c, 0), d); chk("R1 cfg", d, 32'h060000);
      reg_rd(creg(c, 4), d); chk("R1 status", d, 32'h2);
      reg_rd(creg(c, 8), d); chk("R1 ctrl", d, 32'h0);
    end
    chk("R1 outputs idle", {tx_dreq, rx_dreq, tx_empty_evt, rx_full_evt, cs_n, 3'b0, sclk},
        {16'h0, 4'hF, 4'h0});
    reg_rd(8'h04, d); chk("R12 unmapped reads 0", d, 32'h0);
    chk("R12 ready high", 32'(reg_ready), 32'h1);

    // R7/R8: enabled duplex channel, nothing loaded
    reg_wr(creg(0, 0), cfgw(0, 7, 1, 1, 0, 0));
    reg_wr(creg(0, 8), 32'h1);
    @(negedge clk);
    chk("R7 tx dreq when empty", 32'(tx_dreq[0]), 32'h1);
    chk("R7 rx dreq low", 32'(rx_dreq[0]), 32'h0);
    chk("R8 tx empty event", 32'(tx_empty_evt[0]), 32'h1);
    chk("R3 held while empty", 32'(cs_falls), 32'h0);

    // R9/R4 first transfer
    slv_tx = 32'h3C; slv_len = 8;
    base_rises = sclk_rises;
    reg_wr(creg(0, 12), 32'hA5);
    wait_done(0);
    reg_rd(creg(0, 4), d); chk("R4 status after duplex", d, 32'h7);
    reg_rd(creg(0, 12), d); chk("R4 tx zeroed", d, 32'h0);
    chk("R9 mosi msb first", slv_rx, 32'hA5);
    chk("R9 eight sclk pulses", 32'(sclk_rises - base_rises), 32'd8);
    chk("R8 rx full event", 32'(rx_full_evt[0]), 32'h1);
    chk("R7 rx dreq", 32'(rx_dreq[0]), 32'h1);

    // R3 hold off on uncollected receive word
    base_falls = cs_falls;
    reg_wr(creg(0, 12), 32'h11);
    repeat (60) @(negedge clk);
    reg_rd(creg(0, 4), d); chk("R3 held by rx full", d, 32'h5);
    chk("R3 no chip select", 32'(cs_falls - base_falls), 32'h0);

    // R5 read releases the pending transfer
    slv_tx = 32'h5A;
    reg_rd(creg(0, 16), d); chk("R5 rx data", d, 32'h3C);
    wait_done(0);
    chk("R5 pending transfer ran", slv_rx, 32'h11);
    reg_rd(creg(0, 16), d); chk("R5 second rx", d, 32'h5A);
    reg_rd(creg(0, 4), d); chk("R5 rx full cleared", d, 32'h6);

    // R6 turbo
    reg_wr(creg(0, 0), cfgw(0, 7, 0, 1, 1, 0));
    reg_wr(creg(0, 12), 32'h22);
    wait_done(0);
    chk("R8 no rx event in turbo", 32'(rx_full_evt[0]), 32'h0);
    chk("R7 rx dreq in turbo", 32'(rx_dreq[0]), 32'h1);
    reg_wr(creg(0, 12), 32'h33);
    wait_done(0);
    chk("R6 turbo ignores rx full", slv_rx, 32'h33);
    reg_rd(creg(0, 16), d);

    // R4 transmit-only
    reg_wr(creg(0, 0), cfgw(2, 7, 0, 1, 0, 0));
    reg_wr(creg(0, 12), 32'h44);
    wait_done(0);
    reg_rd(creg(0, 4), d); chk("R4 tx-only status", d, 32'h6);
    chk("R7 no rx dreq tx-only", 32'(rx_dreq[0]), 32'h0);
    chk("R4 tx-only shifted", slv_rx, 32'h44);

    // receive-only starts on enable
    reg_wr(creg(0, 8), 32'h0);
    reg_wr(creg(0, 0), cfgw(1, 7, 1, 1, 0, 0));
    slv_tx = 32'h96;
    reg_wr(creg(0, 8), 32'h1);
    wait_done(0);
    reg_rd(creg(0, 4), d); chk("R3 rx-only ran on enable", d, 32'h7);
    chk("R7 no tx dreq rx-only", 32'(tx_dreq[0]), 32'h0);
    chk("R8 no tx event rx-only", 32'(tx_empty_evt[0]), 32'h0);
    chk("R7 rx dreq rx-only", 32'(rx_dreq[0]), 32'h1);
    base_falls = cs_falls;
    reg_rd(creg(0, 16), d); chk("R5 rx-only data", d, 32'h96);
    wait_done(0);
    chk("R5 read restarts rx-only", 32'(cs_falls - base_falls), 32'h1);
    reg_wr(creg(0, 8), 32'h0);
    reg_rd(creg(0, 16), d);

    // R9 short word length clamps to 4
    reg_wr(creg(0, 0), cfgw(2, 0, 0, 0, 0, 0));
    reg_wr(creg(0, 8), 32'h1);
    base_rises = sclk_rises;
    reg_wr(creg(0, 12), 32'hF);
    wait_done(0);
    chk("R9 clamp to 4 bits", 32'(sclk_rises - base_rises), 32'd4);
    reg_wr(creg(0, 8), 32'h0);

    // R10 single mode without force
    reg_rd(creg(0, 16), r0);
    reg_wr(8'h28, 32'h1);
    reg_wr(creg(0, 0), cfgw(0, 7, 0, 0, 0, 0));
    reg_wr(creg(0, 8), 32'h1);
    base_falls = cs_falls; base_rises = sclk_rises;
    reg_wr(creg(0, 12), 32'h77);
    wait_done(0);
    chk("R10 no chip select", 32'(cs_falls - base_falls), 32'h0);
    chk("R10 no sclk", 32'(sclk_rises - base_rises), 32'h0);
    reg_rd(creg(0, 16), d); chk("R10 rx kept", d, r0);
    reg_wr(creg(0, 0), cfgw(0, 7, 0, 0, 0, 1));
    slv_tx = 32'hC3;
    reg_wr(creg(0, 12), 32'h78);
    wait_done(0);
    chk("R10 force selects", 32'(cs_falls - base_falls), 32'h1);
    reg_rd(creg(0, 16), d); chk("R10 force rx", d, 32'hC3);
    reg_wr(creg(0, 8), 32'h0);
    reg_wr(8'h28, 32'h0);

    // R2 masking and ignored writes on channel 3
    reg_wr(creg(3, 0), 32'hFFFF_FFFF);
    reg_rd(creg(3, 0), d); chk("R2 cfg keeps 22:0", d, 32'h7F_FFFF);
    reg_wr(creg(3, 4), 32'h0);
    reg_rd(creg(3, 4), d); chk("R2 status write ignored", d, 32'h2);
    reg_wr(creg(3, 16), 32'h1234);
    reg_rd(creg(3, 16), d); chk("R2 rx write ignored", d, 32'h0);
    reg_wr(creg(3, 8), 32'hFFFF_FFFE);
    reg_rd(creg(3, 8), d); chk("R2 ctrl keeps bit 0", d, 32'h0);

    // R11 priority
    slv_len = 32;
    reg_wr(creg(3, 0), cfgw(0, 31, 0, 0, 0, 0));
    reg_wr(creg(1, 0), cfgw(0, 7, 0, 0, 0, 0));
    reg_wr(creg(2, 0), cfgw(0, 7, 0, 0, 0, 0));
    reg_wr(creg(1, 12), 32'h1);
    reg_wr(creg(2, 12), 32'h2);
    base_falls = cs_falls;
    reg_wr(creg(3, 8), 32'h1);
    reg_wr(creg(3, 12), 32'h3);
    reg_wr(creg(2, 8), 32'h1);
    reg_wr(creg(1, 8), 32'h1);
    for (int t = 0; t < 2000 && cs_falls < base_falls + 3; t++) @(negedge clk);
    wait_done(2);
    chk("R11 first channel 3", 32'(cs_log[base_falls]), 32'd3);
    chk("R11 then channel 1", 32'(cs_log[base_falls+1]), 32'd1);
    chk("R11 then channel 2", 32'(cs_log[base_falls+2]), 32'd2);
    for (int c = 1; c < NCH; c++) reg_wr(creg(c, 8), 32'h0);

    // R9 random words and lengths on channel 0
    reg_wr(creg(0, 8), 32'h1);
    for (int it = 0; it < 20; it++) begin
      len = 4 + int'($urandom_range(28));
      word = $urandom;
      slv_tx = $urandom;
      slv_len = len;
      reg_wr(creg(0, 0), cfgw(0, len - 1, 0, 0, 0, 0));
      reg_wr(creg(0, 12), word);
      wait_done(0);
      chk("R9 random mosi", slv_rx, word & lenmask(len));
      reg_rd(creg(0, 16), d);
      chk("R9 random miso", d, slv_tx & lenmask(len));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule